// File: doc/BRIEF.md
# Shared-Period Multi-Channel PWM Controller

This block produces several pulse-width-modulated outputs from a single free-running counter. All running outputs share one period compare. Each output slot has its own compare value. An output flips when the counter meets its slot compare, and it flips again when the counter meets the shared period compare. The period match also returns the counter to zero. A power-of-two prescaler divides the clock to give the counter tick.

Software-style requests arrive on a valid/ready port. Each request carries an identifier, a period and a pulse width, both in cycles. The block handles a request in three steps. It checks that the period fits the channels already running, it allocates an output slot, and it returns a response code with the slot index one cycle later. Requests with a 0% or 100% duty do not use the counter. They hold the output at a fixed level, mark the slot idle, and stop the counter when no slot is left running. Wide periods are scaled down to fit the counter. The block shifts both values right by the part of the period that lies above the counter width.

Top module: `pwm_share_top`

## Requirements
- R1: After reset, every output is low, the counter is stopped (run_o low), req_ready_o is high and rsp_valid_o is low.
- R2: A request is taken on a cycle where req_valid_i and req_ready_o are both high. rsp_valid_o is high for exactly the next cycle, with rsp_code_o and rsp_slot_o. req_ready_o is low during that response cycle.
- R3: Response codes are 0 = OK, 1 = BAD_PERIOD and 2 = NO_CHANNEL. A request with a pulse that is neither 0 nor equal to its period is answered BAD_PERIOD when all of these hold: some running slot holds a different identifier, and the requested period differs from the stored shared period. Such a request changes no state.
- R4: A pulse of 0 holds the slot output low. A pulse equal to the period holds it high. Either request is never rejected as BAD_PERIOD, and it leaves the slot idle.
- R5: Slot choice works in this order. First, the lowest slot already bound to the same identifier. Otherwise, the highest-index slot whose stored pulse is zero. Otherwise the answer is NO_CHANNEL. On any error rsp_slot_o is 0.
- R6: With period compare P and slot compare C, the output goes high at the tick where the counter equals C. It goes low at the tick where the counter equals P. The cycle lasts P+1 ticks, and the output is high for P−C of them.
- R7: Let the shift amount be period >> CNT_W. Then P = period >> shift and C = pulse >> shift.
- R8: A compare value of 0 matches at counter value 0. When the slot match and the period match fall on the same tick, the output does not change.
- R9: The counter advances once every 2^prescale_i clock cycles.
- R10: An accepted request with a pulse that is neither 0 nor the full period does four things: it clears the counter and prescaler, drives the new slot and every running slot low, sets run_o high, and stores the period as the shared period.
- R11: When an accepted request leaves no slot with a nonzero pulse, the counter stops (run_o low). While stopped, outputs change only on an accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| prescale_i | input | PRE_W | Tick divider exponent |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Request ready |
| req_id_i | input | ID_W | Output identifier |
| req_period_i | input | PER_W | Period in cycles |
| req_pulse_i | input | PER_W | Pulse width in cycles |
| rsp_valid_o | output | 1 | Response valid |
| rsp_code_o | output | 2 | Response code |
| rsp_slot_o | output | SLOT_W | Slot chosen |
| run_o | output | 1 | Counter running |
| pwm_o | output | NUM_CH | Slot outputs |

## Verification
A wrong slot table shows up at the port on the very next response. A stale identifier or pulse gives a wrong code or slot index in the cycle after the request. A wrong shared period shows up as a false BAD_PERIOD on the next conflicting request. Errors in the compare or shift path are visible only over a full period, so the bench counts high cycles across whole periods and compares them with P−C scaled by the prescaler. A missed restart or a missed stop shows at once: an output is not low right after the request, or run_o has the wrong level in the response cycle.

// File: rtl/pwm_share_pkg.sv
package pwm_share_pkg;
  typedef enum logic [1:0] {
    RSP_OK         = 2'd0,
    RSP_BAD_PERIOD = 2'd1,
    RSP_NO_CHAN    = 2'd2
  } rsp_e;
endpackage

// File: rtl/pwm_tick_gen.sv
module pwm_tick_gen #(
  parameter int CNT_W = 16,
  parameter int PRE_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [PRE_W-1:0] prescale_i,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic [CNT_W-1:0] per_cc_i,
  output logic             tick_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             per_hit_o,
  output logic             run_o
);
  localparam int PRE_CNT_W = (1 << PRE_W) - 1;

  logic [PRE_CNT_W-1:0] pre_q, mask;
  logic [CNT_W-1:0]     cnt_q;
  logic                 run_q;

  assign mask      = ~({PRE_CNT_W{1'b1}} << prescale_i);
  assign tick_o    = run_q && (pre_q == mask);
  assign per_hit_o = tick_o && (cnt_q == per_cc_i);
  assign cnt_o     = cnt_q;
  assign run_o     = run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= 1'b0;
      pre_q <= '0;
      cnt_q <= '0;
    end else if (start_i) begin
      run_q <= 1'b1;
      pre_q <= '0;
      cnt_q <= '0;
    end else if (stop_i) begin
      run_q <= 1'b0;
      pre_q <= '0;
      cnt_q <= '0;
    end else if (run_q) begin
      pre_q <= tick_o ? '0 : pre_q + 1'b1;
      if (tick_o) cnt_q <= per_hit_o ? '0 : cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/pwm_slot_alloc.sv
module pwm_slot_alloc
  import pwm_share_pkg::*;
#(
  parameter int NUM_CH = 3,
  parameter int ID_W   = 5,
  parameter int PER_W  = 24,
  localparam int SLOT_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic [ID_W-1:0]   id_i,
  input  logic [PER_W-1:0]  period_i,
  input  logic [PER_W-1:0]  pulse_i,
  input  logic [PER_W-1:0]  per_q_i,
  input  logic [NUM_CH-1:0] bound_i,
  input  logic [NUM_CH-1:0] act_i,
  input  logic [ID_W-1:0]   ids_i [NUM_CH],
  output rsp_e              code_o,
  output logic [SLOT_W-1:0] slot_o,
  output logic              const_o
);
  logic              conflict, own_hit, free_hit;
  logic [SLOT_W-1:0] own_slot, free_slot;

  assign const_o = (pulse_i == '0) || (pulse_i == period_i);

  always_comb begin
    conflict  = 1'b0;
    own_hit   = 1'b0;
    free_hit  = 1'b0;
    own_slot  = '0;
    free_slot = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (act_i[i] && (ids_i[i] != id_i) && (period_i != per_q_i)) conflict = 1'b1;
    end
    // descending walk: last assignment is the lowest matching slot
    for (int i = NUM_CH - 1; i >= 0; i--) begin
      if (bound_i[i] && (ids_i[i] == id_i)) begin
        own_hit  = 1'b1;
        own_slot = SLOT_W'(i);
      end
    end
    // ascending walk: last assignment is the highest free slot
    for (int i = 0; i < NUM_CH; i++) begin
      if (!act_i[i]) begin
        free_hit  = 1'b1;
        free_slot = SLOT_W'(i);
      end
    end
  end

  always_comb begin
    slot_o = '0;
    if (conflict && !const_o) begin
      code_o = RSP_BAD_PERIOD;
    end else if (own_hit) begin
      code_o = RSP_OK;
      slot_o = own_slot;
    end else if (free_hit) begin
      code_o = RSP_OK;
      slot_o = free_slot;
    end else begin
      code_o = RSP_NO_CHAN;
    end
  end
endmodule

// File: rtl/pwm_out_chan.sv
module pwm_out_chan #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             per_hit_i,
  input  logic [CNT_W-1:0] cc_i,
  input  logic             active_i,
  input  logic             load_i,
  input  logic             load_val_i,
  input  logic             restart_i,
  output logic             pwm_o
);
  logic q, ch_hit;

  assign ch_hit = tick_i && (cnt_i == cc_i);
  assign pwm_o  = q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                             q <= 1'b0;
    else if (load_i)                         q <= load_val_i;
    else if (restart_i && active_i)          q <= 1'b0;
    else if (active_i && (per_hit_i ^ ch_hit)) q <= ~q;  // coincident hits cancel
  end
endmodule

// File: rtl/pwm_share_top.sv
module pwm_share_top
  import pwm_share_pkg::*;
#(
  parameter int NUM_CH = 3,
  parameter int ID_W   = 5,
  parameter int PER_W  = 24,
  parameter int CNT_W  = 16,
  parameter int PRE_W  = 3,
  localparam int SLOT_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [PRE_W-1:0]  prescale_i,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [ID_W-1:0]   req_id_i,
  input  logic [PER_W-1:0]  req_period_i,
  input  logic [PER_W-1:0]  req_pulse_i,
  output logic              rsp_valid_o,
  output logic [1:0]        rsp_code_o,
  output logic [SLOT_W-1:0] rsp_slot_o,
  output logic              run_o,
  output logic [NUM_CH-1:0] pwm_o
);
  localparam int SHIFT_W = PER_W - CNT_W;

  logic [ID_W-1:0]   id_q   [NUM_CH];
  logic [PER_W-1:0]  pulse_q[NUM_CH];
  logic [CNT_W-1:0]  cc_q   [NUM_CH];
  logic [NUM_CH-1:0] bound_q, act;
  logic [PER_W-1:0]  per_q;
  logic [CNT_W-1:0]  per_cc_q;
  logic              rsp_valid_q;
  rsp_e              rsp_code_q, code;
  logic [SLOT_W-1:0] rsp_slot_q, slot;
  logic              is_const, accept, take, start, stop, others_act;
  logic [SHIFT_W-1:0] shamt;
  logic [PER_W-1:0]  per_sh, pul_sh;
  logic              tick, per_hit;
  logic [CNT_W-1:0]  cnt;

  assign req_ready_o = !rsp_valid_q;
  assign accept      = req_valid_i && req_ready_o;
  assign take        = accept && (code == RSP_OK);
  assign start       = take && !is_const;
  assign shamt       = req_period_i[PER_W-1:CNT_W];
  assign per_sh      = req_period_i >> shamt;
  assign pul_sh      = req_pulse_i >> shamt;

  always_comb begin
    others_act = 1'b0;
    for (int i = 0; i < NUM_CH; i++) begin
      act[i] = (pulse_q[i] != '0);
      if (act[i] && (SLOT_W'(i) != slot)) others_act = 1'b1;
    end
  end
  assign stop = take && is_const && !others_act;

  pwm_slot_alloc #(.NUM_CH(NUM_CH), .ID_W(ID_W), .PER_W(PER_W)) u_alloc (
    .id_i(req_id_i), .period_i(req_period_i), .pulse_i(req_pulse_i),
    .per_q_i(per_q), .bound_i(bound_q), .act_i(act), .ids_i(id_q),
    .code_o(code), .slot_o(slot), .const_o(is_const)
  );

  pwm_tick_gen #(.CNT_W(CNT_W), .PRE_W(PRE_W)) u_tick (
    .clk_i, .rst_ni, .prescale_i, .start_i(start), .stop_i(stop),
    .per_cc_i(per_cc_q), .tick_o(tick), .cnt_o(cnt), .per_hit_o(per_hit), .run_o
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    logic load_g;
    assign load_g = take && (slot == SLOT_W'(g));

    pwm_out_chan #(.CNT_W(CNT_W)) u_out (
      .clk_i, .rst_ni, .tick_i(tick), .cnt_i(cnt), .per_hit_i(per_hit),
      .cc_i(cc_q[g]), .active_i(act[g]), .load_i(load_g),
      .load_val_i(req_pulse_i != '0 && req_pulse_i == req_period_i),
      .restart_i(start), .pwm_o(pwm_o[g])
    );

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        id_q[g]    <= '0;
        pulse_q[g] <= '0;
        cc_q[g]    <= '0;
        bound_q[g] <= 1'b0;
      end else if (load_g) begin
        id_q[g]    <= req_id_i;
        bound_q[g] <= 1'b1;
        pulse_q[g] <= is_const ? '0 : req_pulse_i;
        if (!is_const) cc_q[g] <= pul_sh[CNT_W-1:0];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      per_q       <= '0;
      per_cc_q    <= '0;
      rsp_valid_q <= 1'b0;
      rsp_code_q  <= RSP_OK;
      rsp_slot_q  <= '0;
    end else begin
      rsp_valid_q <= accept;
      if (accept) begin
        rsp_code_q <= code;
        rsp_slot_q <= (code == RSP_OK) ? slot : '0;
      end
      if (start) begin
        per_q    <= req_period_i;
        per_cc_q <= per_sh[CNT_W-1:0];
      end
    end
  end

  assign rsp_valid_o = rsp_valid_q;
  assign rsp_code_o  = rsp_code_q;
  assign rsp_slot_o  = rsp_slot_q;
endmodule

// File: rtl/pwm_share_chk.sv
module pwm_share_chk #(
  parameter int NUM_CH = 3,
  parameter int ID_W   = 5,
  parameter int PER_W  = 24,
  parameter int PRE_W  = 3,
  localparam int SLOT_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic              req_ready_o,
  input logic [PER_W-1:0]  req_period_i,
  input logic [PER_W-1:0]  req_pulse_i,
  input logic              rsp_valid_o,
  input logic [1:0]        rsp_code_o,
  input logic [SLOT_W-1:0] rsp_slot_o,
  input logic              run_o,
  input logic [NUM_CH-1:0] pwm_o
);
  AST_RSP_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> rsp_valid_o); // R2
  AST_RSP_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> !rsp_valid_o); // R2
  AST_CODE_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> (rsp_code_o != 2'd3)); // R3
  AST_ERR_SLOT_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_code_o != 2'd0) |-> (rsp_slot_o == '0)); // R5
  AST_STOPPED_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_o && !(req_valid_i && req_ready_o)) |=> $stable(pwm_o)); // R11
  AST_START_RUNS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o && req_pulse_i != '0 && req_pulse_i != req_period_i)
    |=> (rsp_code_o != 2'd0 || run_o)); // R10
endmodule

bind pwm_share_top pwm_share_chk #(
  .NUM_CH(NUM_CH), .ID_W(ID_W), .PER_W(PER_W), .PRE_W(PRE_W)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_valid_i(req_valid_i), .req_ready_o(req_ready_o),
  .req_period_i(req_period_i), .req_pulse_i(req_pulse_i), .rsp_valid_o(rsp_valid_o),
  .rsp_code_o(rsp_code_o), .rsp_slot_o(rsp_slot_o), .run_o(run_o), .pwm_o(pwm_o)
);

// File: tb/sim_pwm_share_top.sv
module sim_pwm_share_top;
  localparam int NUM_CH = 3, ID_W = 5, PER_W = 16, CNT_W = 8, PRE_W = 3;
  localparam int SLOT_W = 2;
  localparam int NV = 11;

  typedef struct packed {
    logic [ID_W-1:0]   id;
    logic [PER_W-1:0]  per;
    logic [PER_W-1:0]  pul;
    logic [1:0]        code;
    logic [SLOT_W-1:0] slot;
    logic              run;
    logic [NUM_CH-1:0] mask;
    logic [NUM_CH-1:0] val;
  } vec_t;

  // code: 0 OK, 1 BAD_PERIOD, 2 NO_CHANNEL
  localparam vec_t VEC [NV] = '{
    '{5'd5, 16'd20, 16'd5,  2'd0, 2'd2, 1'b1, 3'b100, 3'b000}, // R5 highest free, R10 low
    '{5'd7, 16'd30, 16'd10, 2'd1, 2'd0, 1'b1, 3'b000, 3'b000}, // R3 conflict
    '{5'd7, 16'd20, 16'd8,  2'd0, 2'd1, 1'b1, 3'b110, 3'b000}, // R5, R10
    '{5'd5, 16'd20, 16'd12, 2'd0, 2'd2, 1'b1, 3'b110, 3'b000}, // R5 same id
    '{5'd9, 16'd30, 16'd30, 2'd0, 2'd0, 1'b1, 3'b001, 3'b001}, // R4 full high
    '{5'd3, 16'd20, 16'd4,  2'd0, 2'd0, 1'b1, 3'b111, 3'b000}, // R5 idle slot reused
    '{5'd4, 16'd20, 16'd4,  2'd2, 2'd0, 1'b1, 3'b000, 3'b000}, // R5 none free
    '{5'd4, 16'd20, 16'd0,  2'd2, 2'd0, 1'b1, 3'b000, 3'b000}, // R5 none free, zero pulse
    '{5'd3, 16'd99, 16'd0,  2'd0, 2'd0, 1'b1, 3'b001, 3'b000}, // R4 zero pulse, odd period
    '{5'd7, 16'd20, 16'd20, 2'd0, 2'd1, 1'b1, 3'b010, 3'b010}, // R4 full high
    '{5'd5, 16'd20, 16'd0,  2'd0, 2'd2, 1'b0, 3'b100, 3'b000}  // R11 last one off
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic [PRE_W-1:0] prescale = '0;
  logic req_valid = 1'b0, req_ready;
  logic [ID_W-1:0] req_id = '0;
  logic [PER_W-1:0] req_period = '0, req_pulse = '0;
  logic rsp_valid, run;
  logic [1:0] rsp_code;
  logic [SLOT_W-1:0] rsp_slot;
  logic [NUM_CH-1:0] pwm;
  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  pwm_share_top #(.NUM_CH(NUM_CH), .ID_W(ID_W), .PER_W(PER_W), .CNT_W(CNT_W), .PRE_W(PRE_W)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .prescale_i(prescale), .req_valid_i(req_valid),
    .req_ready_o(req_ready), .req_id_i(req_id), .req_period_i(req_period),
    .req_pulse_i(req_pulse), .rsp_valid_o(rsp_valid), .rsp_code_o(rsp_code),
    .rsp_slot_o(rsp_slot), .run_o(run), .pwm_o(pwm)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk) rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // leaves the bench at the negedge of the response cycle
  task automatic do_req(input int id, input int per, input int pul);
    @(negedge clk);
    req_valid = 1'b1; req_id = ID_W'(id); req_period = PER_W'(per); req_pulse = PER_W'(pul);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic high_count(input int ch, input int n, output int cnt);
    cnt = 0;
    repeat (n) begin
      @(negedge clk);
      if (pwm[ch]) cnt++;
    end
  endtask

  task automatic duty_case(input string req, input int pre, input int per, input int pul,
                           input int settle, input int win, input int exp);
    int h;
    do_reset();
    prescale = PRE_W'(pre);
    do_req(1, per, pul);
    chk(rsp_code == 2'd0 && rsp_slot == 2'd2, req, rsp_code, 0);
    repeat (settle) @(negedge clk);
    high_count(2, win, h);
    chk(h == exp, req, h, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++; n_run++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    int h;
    @(negedge clk);
    chk(pwm == '0 && !run && req_ready && !rsp_valid, "R1 reset state", {pwm, run, req_ready, rsp_valid}, 3'b010);
    rst_n = 1'b1;

    for (int v = 0; v < NV; v++) begin
      do_req(VEC[v].id, VEC[v].per, VEC[v].pul);
      chk(rsp_valid && !req_ready, "R2 response timing", {rsp_valid, req_ready}, 2);
      chk(rsp_code == VEC[v].code, "R3 code", rsp_code, VEC[v].code);
      chk(rsp_slot == VEC[v].slot, "R5 slot", rsp_slot, VEC[v].slot);
      chk(run == VEC[v].run, "R11 run level", run, VEC[v].run);
      chk((pwm & VEC[v].mask) == VEC[v].val, "R4 levels", pwm & VEC[v].mask, VEC[v].val);
      @(negedge clk);
      chk(!rsp_valid && req_ready, "R2 single response", {rsp_valid, req_ready}, 1);
    end
    repeat (20) @(negedge clk);
    chk(pwm == 3'b010, "R11 stopped outputs hold", pwm, 2);

    // R6: P=20, C=5 -> 15 high of 21
    duty_case("R6 duty", 0, 20, 5, 42, 42, 30);
    // R9: prescale 2 -> four clocks per tick
    duty_case("R9 prescale", 2, 20, 5, 200, 168, 120);
    // R7: shift 3 -> P=96, C=32
    duty_case("R7 shift", 0, 16'h300, 16'h100, 200, 97, 64);
    // R8: C shifts to 0 -> high 96 of 97
    duty_case("R8 zero compare", 0, 16'h300, 16'h5, 200, 97, 96);
    // R8: C equals P after shift -> never high
    duty_case("R8 coincident", 0, 16'h301, 16'h300, 200, 194, 0);

    // R10: restart forces running slot low
    do_reset();
    prescale = '0;
    do_req(1, 20, 5);
    repeat (9) @(negedge clk);
    chk(pwm[2] == 1'b1, "R10 slot high before restart", pwm[2], 1);
    do_req(2, 20, 10);
    chk(pwm[2:1] == 2'b00 && run, "R10 restart low", {pwm[2:1], run}, 1);
    do_req(3, 25, 10);
    chk(rsp_code == 2'd1, "R3 conflict", rsp_code, 1);
    high_count(2, 42, h);
    chk(h == 30, "R3 state kept", h, 30);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule